// File: doc/BRIEF.md
# Block Transfer Micro-Op Sequencer

This block turns one decoded block-transfer memory instruction into a run of doubleword micro-operations for a load/store unit. An instruction arrives with four operands: a base register value, a second operand, an index for its register group and a privilege status for its access space. The second operand is either a register value or a signed 13-bit immediate. The instruction also carries a load/store indicator and a mode select. Block mode moves eight consecutive doublewords. Twin mode moves two, into the low and then the high half of a register pair.

The sequencer accepts one instruction while it is idle. It first computes and checks the base effective address. It then presents one micro-op per handshake toward the memory stage. Each micro-op carries a stepped address, a stepped register index, a step number and commit flags. The first micro-op also carries a fault code. A faulting instruction produces a single fault beat and no memory micro-ops.

Top module: `block_xfer_seq`

## Requirements
- R1: A synchronous reset makes the block idle on the next clock edge. After that edge `out_valid`, `out_last`, `out_delay_commit` and `out_fault_code` are 0 and `in_ready` is 1. This holds even if a sequence was in progress.
- R2: `in_ready` is 1 only when no instruction is in progress. While a sequence runs, `in_valid` and all instruction inputs are ignored and the sequence continues unchanged.
- R3: A block-mode instruction (`in_twin`=0) with no fault presents exactly 8 micro-ops, with `out_step` 0 to 7 in order. After the last handshake, `out_valid` is 0 and `in_ready` is 1.
- R4: A twin-mode instruction (`in_twin`=1) with no fault presents exactly 2 micro-ops (`out_step` 0 then 1). Step 0 targets register index `in_rd` (the low half of the pair) and step 1 targets `in_rd`+1 (the high half).
- R5: The address of step N is EA + 8·N, modulo 2^AW. EA is `in_base` + `in_rs2` when `in_use_imm`=0. When `in_use_imm`=1, EA is `in_base` + the two's-complement value of `in_imm` (range −4096 to 4095).
- R6: The register index of step N is `in_rd` + N, modulo 2^RIW.
- R7: The final micro-op has `out_last`=1 and `out_delay_commit`=0. Every earlier micro-op has `out_delay_commit`=1 and `out_last`=0.
- R8: While `out_valid`=1 and `out_ready`=0, every micro-op output holds its value. The sequence advances by one step on each cycle in which both are 1.
- R9: Block mode requires EA[5:0]=0 and twin mode requires EA[3:0]=0. A violation produces one beat with `out_fault_code`=2'b10, step 0, address EA and `out_last`=1, and no further micro-ops.
- R10: With `in_priv_ok`=0 and an aligned EA, the single fault beat carries `out_fault_code`=2'b01. When both faults apply, the alignment code 2'b10 is reported. Code 2'b00 means no fault.
- R11: Only step 0 can carry a nonzero fault code. Steps 1 and later always report 2'b00.
- R12: `out_store` equals the `in_store` value captured with the instruction, on every micro-op of that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction taken when valid |
| in_twin | input | 1 | 0 = block mode (8 steps), 1 = twin mode (2 steps) |
| in_store | input | 1 | 1 = store, 0 = load |
| in_use_imm | input | 1 | 1 = immediate operand, 0 = second register |
| in_base | input | AW | Base register value |
| in_rs2 | input | AW | Second register value |
| in_imm | input | 13 | Signed immediate field |
| in_rd | input | RIW | First register index of the group |
| in_priv_ok | input | 1 | Access space permitted at current privilege |
| out_valid | output | 1 | Micro-op presented |
| out_ready | input | 1 | Memory stage takes the micro-op |
| out_addr | output | AW | Effective address of this micro-op |
| out_reg | output | RIW | Register index of this micro-op |
| out_step | output | 3 | Micro-op number |
| out_store | output | 1 | Store indicator of the instruction |
| out_last | output | 1 | Final micro-op of the instruction |
| out_delay_commit | output | 1 | Commit deferred until the final micro-op |
| out_fault_code | output | 2 | 00 none, 01 privilege, 10 alignment |

## Verification
The bench builds the sequencer with a 16-bit address and a 5-bit register index. With these widths, the address wrap past 0xFFFF and the register-index wrap past 31 both occur within one sweep. Each mode is swept across all 64 values of the low six bits of EA, with both privilege states and both operand forms. This covers every alignment case, both fault priorities and negative immediates. A rolling pattern of back-pressure and of inputs offered while busy runs through the same sweep.

// File: rtl/block_xfer_seq.sv
module block_xfer_seq #(
  parameter int AW  = 64,
  parameter int RIW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           in_twin,
  input  logic           in_store,
  input  logic           in_use_imm,
  input  logic [AW-1:0]  in_base,
  input  logic [AW-1:0]  in_rs2,
  input  logic [12:0]    in_imm,
  input  logic [RIW-1:0] in_rd,
  input  logic           in_priv_ok,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [AW-1:0]  out_addr,
  output logic [RIW-1:0] out_reg,
  output logic [2:0]     out_step,
  output logic           out_store,
  output logic           out_last,
  output logic           out_delay_commit,
  output logic [1:0]     out_fault_code
);
  localparam logic [1:0] FLT_NONE  = 2'b00;
  localparam logic [1:0] FLT_PRIV  = 2'b01;
  localparam logic [1:0] FLT_ALIGN = 2'b10;
  localparam logic [2:0] BLK_LAST  = 3'd7;
  localparam logic [2:0] TWN_LAST  = 3'd1;

  logic           busy_q;
  logic [2:0]     step_q;
  logic           twin_q, store_q;
  logic [AW-1:0]  ea_q;
  logic [RIW-1:0] rd_q;
  logic [1:0]     flt_q;

  logic [AW-1:0]  opnd, ea_in;
  logic           misalign;
  logic [1:0]     flt_in;
  logic           accept, advance, final_step;

  assign opnd     = in_use_imm ? {{(AW-13){in_imm[12]}}, in_imm} : in_rs2;
  assign ea_in    = in_base + opnd;
  assign misalign = in_twin ? (ea_in[3:0] != 4'd0) : (ea_in[5:0] != 6'd0);

  always_comb begin
    flt_in = FLT_NONE;
    if (!in_priv_ok) flt_in = FLT_PRIV;
    if (misalign)    flt_in = FLT_ALIGN;
  end

  assign in_ready   = !busy_q;
  assign accept     = in_valid && !busy_q;
  assign final_step = (flt_q != FLT_NONE) ||
                      (step_q == (twin_q ? TWN_LAST : BLK_LAST));
  assign advance    = busy_q && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      step_q  <= 3'd0;
      twin_q  <= 1'b0;
      store_q <= 1'b0;
      ea_q    <= '0;
      rd_q    <= '0;
      flt_q   <= FLT_NONE;
    end else if (accept) begin
      busy_q  <= 1'b1;
      step_q  <= 3'd0;
      twin_q  <= in_twin;
      store_q <= in_store;
      ea_q    <= ea_in;
      rd_q    <= in_rd;
      flt_q   <= flt_in;
    end else if (advance) begin
      if (final_step) begin
        busy_q <= 1'b0;
        flt_q  <= FLT_NONE;
      end else begin
        step_q <= step_q + 3'd1;
      end
    end
  end

  assign out_valid        = busy_q;
  assign out_addr         = ea_q + AW'({step_q, 3'b000});
  assign out_reg          = rd_q + RIW'(step_q);
  assign out_step         = step_q;
  assign out_store        = store_q;
  assign out_last         = busy_q && final_step;
  assign out_delay_commit = busy_q && !final_step;
  assign out_fault_code   = (busy_q && step_q == 3'd0) ? flt_q : FLT_NONE;
endmodule

// File: rtl/block_xfer_seq_chk.sv
module block_xfer_seq_chk #(
  parameter int AW  = 64,
  parameter int RIW = 6
) (
  input logic           clk,
  input logic           rst,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [AW-1:0]  out_addr,
  input logic [RIW-1:0] out_reg,
  input logic [2:0]     out_step,
  input logic           out_last,
  input logic           out_delay_commit,
  input logic [1:0]     out_fault_code
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready && !out_last && !out_delay_commit));

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R7
  one_flag_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_last != out_delay_commit));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_addr) && $stable(out_reg) && $stable(out_step)
       && $stable(out_last) && $stable(out_fault_code)));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_last) |=>
      (out_valid && out_addr == $past(out_addr) + AW'(8)));

  // R6
  reg_step_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_last) |=>
      (out_reg == $past(out_reg) + RIW'(1)));

  // R3
  end_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> !out_valid);

  // R11
  fault_first_chk: assert property (@(posedge clk) disable iff (rst)
    (out_fault_code != 2'b00) |-> (out_step == 3'd0 && out_last));

  // R10
  fault_code_chk: assert property (@(posedge clk) disable iff (rst)
    out_fault_code != 2'b11);
endmodule

bind block_xfer_seq block_xfer_seq_chk #(.AW(AW), .RIW(RIW)) chk_i (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_addr(out_addr), .out_reg(out_reg),
  .out_step(out_step), .out_last(out_last),
  .out_delay_commit(out_delay_commit), .out_fault_code(out_fault_code)
);

// File: tb/block_xfer_seq_test.sv
module block_xfer_seq_test;
  localparam int AW  = 16;
  localparam int RIW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_twin = 1'b0, in_store = 1'b0, in_use_imm = 1'b0;
  logic in_priv_ok = 1'b1, out_ready = 1'b0;
  logic [AW-1:0] in_base = '0, in_rs2 = '0;
  logic [12:0] in_imm = '0;
  logic [RIW-1:0] in_rd = '0;
  logic in_ready, out_valid, out_store, out_last, out_delay_commit;
  logic [AW-1:0] out_addr;
  logic [RIW-1:0] out_reg;
  logic [2:0] out_step;
  logic [1:0] out_fault_code;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  block_xfer_seq #(.AW(AW), .RIW(RIW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_twin(in_twin), .in_store(in_store), .in_use_imm(in_use_imm),
    .in_base(in_base), .in_rs2(in_rs2), .in_imm(in_imm), .in_rd(in_rd),
    .in_priv_ok(in_priv_ok), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_reg(out_reg), .out_step(out_step),
    .out_store(out_store), .out_last(out_last),
    .out_delay_commit(out_delay_commit), .out_fault_code(out_fault_code)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_beat(input int k, input int n, input logic [AW-1:0] addr,
                            input logic [RIW-1:0] rg, input logic [1:0] code,
                            input bit st, input bit twin);
    chk(out_valid == 1'b1, twin ? "R4 valid" : "R3 valid", out_valid, 1);
    chk(out_step == 3'(k), twin ? "R4 step" : "R3 step", out_step, k);
    chk(out_addr == addr, "R5 address", out_addr, addr);
    chk(out_reg == rg, twin ? "R4 pair index" : "R6 index", out_reg, rg);
    chk(out_last == (k == n - 1), "R7 last", out_last, k == n - 1);
    chk(out_delay_commit == (k != n - 1), "R7 delayed commit", out_delay_commit, k != n - 1);
    chk(out_fault_code == code, k == 0 ? "R10 fault code" : "R11 fault code",
        out_fault_code, code);
    chk(out_store == st, "R12 store", out_store, st);
  endtask

  task automatic run(input bit twin, input bit st, input bit use_imm,
                     input logic [AW-1:0] base, input logic [AW-1:0] rs2,
                     input logic [12:0] imm, input logic [RIW-1:0] rd,
                     input bit priv, input int seed, input bit junk);
    int imm_val, n;
    logic [AW-1:0] ea;
    logic [1:0] code;
    bit mis;
    @(negedge clk);
    chk(in_ready == 1'b1, "R2 idle ready", in_ready, 1);
    in_twin = twin; in_store = st; in_use_imm = use_imm; in_base = base;
    in_rs2 = rs2; in_imm = imm; in_rd = rd; in_priv_ok = priv; in_valid = 1'b1;
    @(negedge clk);
    in_valid = junk;
    if (junk) begin
      in_twin = ~twin; in_store = ~st; in_base = ~base; in_rd = ~rd; in_priv_ok = ~priv;
    end
    imm_val = int'(imm) - (imm[12] ? 8192 : 0);
    ea = use_imm ? AW'(int'(base) + imm_val) : AW'(int'(base) + int'(rs2));
    mis = twin ? (ea % 16 != 0) : (ea % 64 != 0);
    code = mis ? 2'b10 : (!priv ? 2'b01 : 2'b00);
    n = (code != 2'b00) ? 1 : (twin ? 2 : 8);
    for (int k = 0; k < n; k++) begin
      logic [AW-1:0] a;
      logic [RIW-1:0] r;
      a = AW'(int'(ea) + 8 * k);
      r = RIW'(int'(rd) + k);
      if ((seed + k) % 3 == 0) begin
        out_ready = 1'b0;
        check_beat(k, n, a, r, code, st, twin);
        @(negedge clk);
        chk(out_valid && out_step == 3'(k) && out_addr == a, "R8 hold", out_addr, a);
      end
      out_ready = 1'b1;
      check_beat(k, n, a, r, code, st, twin);
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b0;
    chk(out_valid == 1'b0, code != 2'b00 ? "R9 no further beats" :
        (junk ? "R2 busy input ignored" : "R3 sequence end"), out_valid, 0);
    chk(in_ready == 1'b1, "R3 ready after end", in_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && in_ready == 1, "R1 reset outputs", out_valid, 0);
    chk(out_last == 0 && out_delay_commit == 0 && out_fault_code == 0, "R1 reset flags",
        {out_last, out_delay_commit, out_fault_code}, 0);
    rst = 1'b0;
    for (int tw = 0; tw < 2; tw++)
      for (int i = 0; i < 64; i++)
        for (int p = 0; p < 2; p++)
          run(tw[0], i[1], i[0], AW'(16'hFFC0 - i * 64), AW'(i + 16'h0100),
              13'(i - 32), RIW'(i), p[0], i + p, (i % 4) == 1);
    run(1'b0, 1'b1, 1'b1, 16'h2000, 16'h0, 13'h1000, 5'd3, 1'b1, 1, 1'b0);
    run(1'b1, 1'b0, 1'b1, 16'h0008, 16'h0, 13'h1FF8, 5'd31, 1'b1, 0, 1'b0);
    @(negedge clk);
    in_twin = 1'b0; in_use_imm = 1'b0; in_base = 16'h4000; in_rs2 = 16'h0;
    in_priv_ok = 1'b1; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1 && out_step == 3'd1, "R1 mid-sequence setup", out_step, 1);
    rst = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && in_ready == 1 && out_delay_commit == 0, "R1 reset mid-sequence",
        out_valid, 0);
    rst = 1'b0;
    out_ready = 1'b0;
    @(negedge clk);
    chk(out_valid == 0, "R1 stays idle", out_valid, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule